// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block stores incoming frames into memory by walking a ring of two-word receive descriptors that it shares with software. It takes frame bytes on a byte stream with valid, last and ready, plus a bad-checksum flag sampled with the last byte. For each buffer it needs, it reads the descriptor's first word through a simple word-wide memory port. If hardware owns the descriptor, it writes the frame bytes into the buffer that word points to. It then writes a status word and returns the descriptor to software by setting its ownership bit.

A frame that is longer than one buffer continues in the following descriptors. The buffer size is a programmable count of 64-byte units. The status word marks the first and the last buffer of a frame. The descriptor holding the last buffer also carries the frame length and the bad-checksum mark. When the engine meets a descriptor that software still owns, it pulses a no-buffer flag and discards the rest of the frame. It tries that same descriptor again on the next frame. A one-cycle pulse reports each frame that has been fully stored.

Memory reads return data in the cycle after the request, and the port never stalls. The ring base address and the buffer size are expected to stay steady while the engine is enabled.

Top module: `rxd_ring_engine`

## Requirements
- R1: Descriptor word 0 holds the buffer address in bits 31:2, the wrap flag in bit 1 and the ownership bit in bit 0. The two low address bits are taken as zero. Every memory access uses a word-aligned address.
- R2: The engine writes only into descriptors whose word 0 bit 0 is 0. On reading a 1 there, it pulses no_buf_o for one cycle, makes no memory writes until the frame's last byte, and uses that same descriptor for the next frame.
- R3: Once a buffer is finished, the engine writes word 1 (descriptor address + 4) and then word 0. Word 0 keeps the original address and wrap bits and has bit 0 set to 1.
- R4: After a descriptor is handed back, the next descriptor is the ring base if its wrap bit was set, and otherwise the current address + 8.
- R5: Each buffer holds buf_units_i × 64 bytes. A frame is split over consecutive descriptors, and every buffer except the last is filled completely. A frame of exactly one buffer size uses one descriptor.
- R6: Word 1 bit 14 is set only in the first buffer of a frame, and bit 15 only in the last. A single-buffer frame has both bits set.
- R7: Word 1 bits 12:0 hold the frame's byte count in the descriptor with bit 15 set, and are zero in all other descriptors.
- R8: Word 1 bit 13 equals rx_bad_fcs_i sampled with the last byte, in the last descriptor only. Word 1 bits 31:16 are zero.
- R9: Byte n of a buffer sits in bits 8*(n mod 4)+7:8*(n mod 4) of the word at buffer address + 4*(n div 4). Unused byte lanes of a final partial word are written as zero.
- R10: frame_rcvd_o pulses for one cycle in the same cycle as the word-0 write of a frame's last descriptor, and at no other time.
- R11: While en_i is low, from the next cycle on, rx_ready_o is low, no memory access happens, and the descriptor pointer reloads from ring_base_i. After enabling, the first descriptor fetched is at ring_base_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable; low reloads the pointer from the base |
| ring_base_i | input | 32 | Byte address of the first descriptor |
| buf_units_i | input | 8 | Buffer size in 64-byte units, nonzero |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_bad_fcs_i | input | 1 | Frame checksum bad, sampled with the last byte |
| rx_ready_o | output | 1 | Byte accepted when high together with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| frame_rcvd_o | output | 1 | One-cycle pulse when a frame is fully stored |
| no_buf_o | output | 1 | One-cycle pulse when a software-owned descriptor is read |

## Verification
The properties assume that the memory port always accepts a request and returns read data exactly one cycle later. They also assume that ring_base_i and buf_units_i change only while en_i is low. The bench's memory model answers every read on the following edge. The bench changes the base and the buffer size only after dropping the enable, and it rewrites descriptors only between frames, while the engine is idle. Frames are kept shorter than the 13-bit length field, so the length never wraps.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned DESC_STEP = 8;
  localparam int unsigned W1_OFS    = 4;
  localparam int unsigned OWN_B     = 0;
  localparam int unsigned WRAP_B    = 1;
  localparam int unsigned LEN_W     = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHK, ST_RECV, ST_WDATA, ST_WB1, ST_WB0, ST_DROP
  } rxd_state_e;

  // word-1 status, low half; bit order is decoded by software
  typedef struct packed {
    logic             eof;
    logic             sof;
    logic             fcs_bad;
    logic [LEN_W-1:0] len;
  } rxd_stat_t;
endpackage

// File: rtl/rxd_byte_pack.sv
module rxd_byte_pack #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 push_i,
  input  logic                                 clear_i,
  input  logic [BYTE_W-1:0]                    byte_i,
  output logic [WORD_W-1:0]                    word_o,
  output logic [$clog2(WORD_W/BYTE_W)-1:0]     lane_o
);
  localparam int unsigned LANES  = WORD_W / BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane_q;
  logic [BYTE_W-1:0] lanes_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lane_q <= '0;
    else if (clear_i) lane_q <= '0;
    else if (push_i)  lane_q <= lane_q + LANE_W'(1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 lanes_q[g] <= '0;
      else if (clear_i)                            lanes_q[g] <= '0;
      else if (push_i && lane_q == LANE_W'(g))     lanes_q[g] <= byte_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = lanes_q[g];
  end

  assign lane_o = lane_q;
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (adv_i)  ptr_q <= wrap_i ? base_i : ptr_q + ADDR_W'(STEP);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SIZE_W     = 8,
  parameter int unsigned UNIT_SHIFT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] ring_base_i,
  input  logic [SIZE_W-1:0] buf_units_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_bad_fcs_i,
  output logic              rx_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              frame_rcvd_o,
  output logic              no_buf_o
);
  localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);
  localparam int unsigned CNT_W      = SIZE_W + UNIT_SHIFT + 1;

  rxd_state_e        state_q, state_d;
  logic [WORD_W-1:0] ptr, buf_base_q, pk_word;
  logic              wrap_q, sof_q, eof_q, full_q, fcs_q;
  logic [CNT_W-1:0]  buf_cnt_q, wr_off_q, buf_bytes;
  logic [LEN_W-1:0]  len_q;
  logic [LANE_W-1:0] pk_lane;
  logic              accept, last_in_buf, pk_clear, ptr_adv;
  rxd_stat_t         stat;

  assign buf_bytes   = CNT_W'(buf_units_i) << UNIT_SHIFT;
  assign accept      = (state_q == ST_RECV) && rx_valid_i;
  assign last_in_buf = (buf_cnt_q + CNT_W'(1)) == buf_bytes;
  assign rx_ready_o  = (state_q == ST_RECV) || (state_q == ST_DROP);

  assign stat.eof     = eof_q;
  assign stat.sof     = sof_q;
  assign stat.fcs_bad = eof_q & fcs_q;
  assign stat.len     = eof_q ? len_q : '0;

  rxd_byte_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .clear_i (pk_clear),
    .byte_i  (rx_data_i),
    .word_o  (pk_word),
    .lane_o  (pk_lane)
  );

  rxd_ring_ptr #(.ADDR_W(WORD_W), .STEP(DESC_STEP)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!en_i),
    .base_i (ring_base_i),
    .adv_i  (ptr_adv),
    .wrap_i (wrap_q),
    .ptr_o  (ptr)
  );

  always_comb begin
    state_d      = state_q;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = ptr;
    mem_wdata_o  = '0;
    frame_rcvd_o = 1'b0;
    no_buf_o     = 1'b0;
    pk_clear     = !en_i;
    ptr_adv      = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (rx_valid_i) state_d = ST_FETCH;
      ST_FETCH: begin
        mem_req_o = 1'b1;
        state_d   = ST_CHK;
      end
      ST_CHK: begin
        if (mem_rdata_i[OWN_B]) begin
          no_buf_o = 1'b1;
          state_d  = ST_DROP;
        end else begin
          state_d  = ST_RECV;
        end
      end
      ST_RECV: begin
        // flush on a full word, end of frame, or end of buffer
        if (accept && (pk_lane == LANE_W'(WORD_BYTES - 1) || rx_last_i || last_in_buf))
          state_d = ST_WDATA;
      end
      ST_WDATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_base_q + WORD_W'(wr_off_q);
        mem_wdata_o = pk_word;
        pk_clear    = 1'b1;
        state_d     = (eof_q || full_q) ? ST_WB1 : ST_RECV;
      end
      ST_WB1: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + WORD_W'(W1_OFS);
        mem_wdata_o = WORD_W'(stat);
        state_d     = ST_WB0;
      end
      ST_WB0: begin
        mem_req_o    = 1'b1;
        mem_we_o     = 1'b1;
        mem_wdata_o  = {buf_base_q[WORD_W-1:2], wrap_q, 1'b1};
        ptr_adv      = 1'b1;
        frame_rcvd_o = eof_q;
        state_d      = eof_q ? ST_IDLE : ST_FETCH;
      end
      ST_DROP:  if (rx_valid_i && rx_last_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (!en_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      buf_base_q <= '0;
      wrap_q     <= 1'b0;
      buf_cnt_q  <= '0;
      wr_off_q   <= '0;
      len_q      <= '0;
      sof_q      <= 1'b1;
      eof_q      <= 1'b0;
      full_q     <= 1'b0;
      fcs_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!en_i) begin
        buf_cnt_q <= '0;
        wr_off_q  <= '0;
        len_q     <= '0;
        sof_q     <= 1'b1;
        eof_q     <= 1'b0;
        full_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CHK: if (!mem_rdata_i[OWN_B]) begin
            buf_base_q <= {mem_rdata_i[WORD_W-1:2], 2'b00};
            wrap_q     <= mem_rdata_i[WRAP_B];
          end
          ST_RECV: if (accept) begin
            buf_cnt_q <= buf_cnt_q + CNT_W'(1);
            len_q     <= len_q + LEN_W'(1);
            full_q    <= last_in_buf;
            if (rx_last_i) begin
              eof_q <= 1'b1;
              fcs_q <= rx_bad_fcs_i;
            end
          end
          ST_WDATA: wr_off_q <= wr_off_q + CNT_W'(WORD_BYTES);
          ST_WB0: begin
            buf_cnt_q <= '0;
            wr_off_q  <= '0;
            full_q    <= 1'b0;
            if (eof_q) begin
              eof_q <= 1'b0;
              sof_q <= 1'b1;
              len_q <= '0;
            end else begin
              sof_q <= 1'b0;
            end
          end
          ST_DROP: if (rx_valid_i && rx_last_i) begin
            sof_q <= 1'b1;
            len_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxd_ring_engine_chk.sv
module rxd_ring_engine_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rx_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              frame_rcvd_o,
  input logic              no_buf_o
);
  p_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // read data is consumed in the following cycle, which carries no access
  p_fetch_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

  p_nobuf_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_buf_o |=> !mem_req_o);

  p_pulse_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_rcvd_o, no_buf_o}));

  p_handback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rcvd_o |-> (mem_req_o && mem_we_o && mem_wdata_o[0]));

  p_no_accept_on_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !mem_req_o);

  p_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rx_ready_o && !mem_req_o));
endmodule

bind rxd_ring_engine rxd_ring_engine_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .rx_ready_o   (rx_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .frame_rcvd_o (frame_rcvd_o),
  .no_buf_o     (no_buf_o)
);

// File: tb/test_rxd_ring_engine.sv
module test_rxd_ring_engine;
  localparam logic [31:0] BASE = 32'h40;

  logic        clk = 1'b0;
  logic        rst_ni, en, rx_valid, rx_last, rx_bad;
  logic [7:0]  rx_data, units;
  logic [31:0] base;
  logic        rx_ready_o, mem_req_o, mem_we_o, frame_rcvd_o, no_buf_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata;

  always #2 clk = ~clk;

  rxd_ring_engine i_rxd_ring_engine (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .ring_base_i  (base),
    .buf_units_i  (units),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .rx_last_i    (rx_last),
    .rx_bad_fcs_i (rx_bad),
    .rx_ready_o   (rx_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata),
    .frame_rcvd_o (frame_rcvd_o),
    .no_buf_o     (no_buf_o)
  );

  typedef struct packed {
    logic [31:0] d;
    logic [31:0] b;
    logic        wr;
    logic [31:0] w1;
    logic [15:0] n;
    logic [7:0]  s;
  } exp_t;

  logic [31:0] mem [1024];
  exp_t        q[$];
  exp_t        e;
  int          n_chk = 0, n_fail = 0, nobuf_seen = 0, wr_seen = 0, bsz = 64, model_idx = 0;
  bit          model_own [4];
  bit          done = 0;

  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[11:2]] = mem_wdata_o;
      wr_seen++;
    end
    if (mem_req_o && !mem_we_o) mem_rdata <= mem[mem_addr_o[11:2]];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] baddr(input int i);
    return 32'h400 + 32'(i) * 32'h100;
  endfunction

  task automatic arm(input int i);
    mem[(BASE + 32'(8 * i)) >> 2]     = {baddr(i)[31:2], (i == 3), 1'b0};
    mem[(BASE + 32'(8 * i) + 4) >> 2] = 32'h0000_DEAD;
    for (int k = 0; k < 64; k++) mem[(baddr(i) >> 2) + 32'(k)] = 32'hFFFF_FFFF;
    model_own[i] = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input bit bad);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_last = last; rx_bad = bad;
    while (!rx_ready_o) @(negedge clk);
    @(posedge clk);
  endtask

  // scoreboard driver: predicts descriptor handbacks, then streams the frame
  task automatic send_frame(input int len, input logic [7:0] seed, input bit bad);
    int rem = len, off = 0, chunk;
    bit first = 1'b1, eof;
    exp_t x;
    while (rem > 0) begin
      if (model_own[model_idx]) break;
      chunk = (rem < bsz) ? rem : bsz;
      eof   = (chunk == rem);
      x.d   = BASE + 32'(8 * model_idx);
      x.b   = baddr(model_idx);
      x.wr  = (model_idx == 3);
      x.w1  = {16'h0, eof, first, eof & bad, eof ? 13'(len) : 13'd0};
      x.n   = 16'(chunk);
      x.s   = seed + 8'(off);
      q.push_back(x);
      model_own[model_idx] = 1'b1;
      model_idx = (model_idx == 3) ? 0 : model_idx + 1;
      rem -= chunk; off += chunk; first = 1'b0;
    end
    for (int k = 0; k < len; k++) send_byte(seed + 8'(k), k == len - 1, bad);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // monitor: compares every descriptor handback against the queue
  always @(negedge clk) begin
    if (rst_ni) begin
      if (no_buf_o) nobuf_seen++;
      if (mem_req_o && mem_we_o && mem_addr_o < 32'h100 && !mem_addr_o[2] && mem_wdata_o[0]) begin
        if (q.size() == 0) begin
          chk("R2", "unexpected handback addr", mem_addr_o, 32'hFFFF_FFFF);
        end else begin
          logic ok;
          e = q.pop_front();
          chk("R4", "descriptor address", mem_addr_o, e.d);
          chk("R1", "word0 address field", {mem_wdata_o[31:2], 2'b00}, e.b);
          chk("R3", "word0 handback", mem_wdata_o, {e.b[31:2], e.wr, 1'b1});
          chk("R6", "word1 sof/eof", {30'h0, mem[(e.d + 4) >> 2][15:14]}, {30'h0, e.w1[15:14]});
          chk("R7", "word1 length", {19'h0, mem[(e.d + 4) >> 2][12:0]}, {19'h0, e.w1[12:0]});
          chk("R8", "word1 fcs/upper", {mem[(e.d + 4) >> 2][31:16], 15'h0, mem[(e.d + 4) >> 2][13]},
              {e.w1[31:16], 15'h0, e.w1[13]});
          chk("R10", "frame pulse", {31'h0, frame_rcvd_o}, {31'h0, e.w1[15]});
          ok = 1'b1;
          for (int i = 0; i < int'(e.n); i++)
            if (mem[(e.b >> 2) + 32'(i / 4)][8 * (i % 4) +: 8] !== e.s + 8'(i)) ok = 1'b0;
          for (int i = int'(e.n); i % 4 != 0; i++)
            if (mem[(e.b >> 2) + 32'(i / 4)][8 * (i % 4) +: 8] !== 8'h00) ok = 1'b0;
          chk("R9", "buffer bytes", {31'h0, ok}, 32'h1);
          chk("R5", "bytes in buffer", {16'h0, e.n}, {16'h0, (e.w1[15] ? e.n : 16'(bsz))});
        end
      end else if (frame_rcvd_o) begin
        chk("R10", "pulse without handback", 32'h1, 32'h0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : main
    int nb, w;
    rst_ni = 1'b0; en = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_bad = 1'b0;
    base = BASE; units = 8'd1; bsz = 64;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk("R11", "ready in reset", {31'h0, rx_ready_o}, 32'h0);
    chk("R11", "req in reset", {31'h0, mem_req_o}, 32'h0);
    chk("R10", "frame pulse in reset", {31'h0, frame_rcvd_o}, 32'h0);
    chk("R2", "no_buf in reset", {31'h0, no_buf_o}, 32'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) arm(i);
    @(negedge clk); en = 1'b1;

    send_frame(10, 8'h10, 1'b0);    // single buffer, partial last word
    send_frame(150, 8'h80, 1'b0);   // three buffers, wraps
    chk("R5", "handbacks pending after split frame", 32'(q.size()), 32'h0);

    nb = nobuf_seen; w = wr_seen;   // descriptor 0 still owned by software
    send_frame(4, 8'h20, 1'b1);
    chk("R2", "no_buf pulses at frame start", 32'(nobuf_seen - nb), 32'h1);
    chk("R2", "writes while dropping", 32'(wr_seen - w), 32'h0);

    for (int i = 0; i < 4; i++) arm(i);
    send_frame(4, 8'h30, 1'b1);     // retry same descriptor, bad checksum kept
    chk("R2", "retry consumed", 32'(q.size()), 32'h0);

    mem[(BASE + 32'd16) >> 2][0] = 1'b1;
    model_own[2] = 1'b1;
    nb = nobuf_seen;
    send_frame(100, 8'h50, 1'b0);   // runs out of buffers mid-frame
    chk("R2", "no_buf pulses mid-frame", 32'(nobuf_seen - nb), 32'h1);
    chk("R6", "first-buffer handback seen", 32'(q.size()), 32'h0);

    arm(2);
    send_frame(64, 8'h60, 1'b0);    // exactly one full buffer
    chk("R5", "exact-fit handback seen", 32'(q.size()), 32'h0);

    @(negedge clk); en = 1'b0;
    rx_valid = 1'b1; rx_data = 8'hAA; rx_last = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11", "ready while disabled", {31'h0, rx_ready_o}, 32'h0);
      chk("R11", "req while disabled", {31'h0, mem_req_o}, 32'h0);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    units = 8'd2; bsz = 128;
    for (int i = 0; i < 4; i++) arm(i);
    model_idx = 0;
    @(negedge clk); en = 1'b1;
    send_frame(130, 8'h90, 1'b0);   // pointer restarts at base, 128-byte buffers
    chk("R11", "restart handbacks seen", 32'(q.size()), 32'h0);

    done = 1'b1;
    report();
  end
endmodule